// File: doc/BRIEF.md
# Floating-Point Status Word with Sticky Exception Flags

This block holds the 32-bit control and status word that sits beside a floating-point arithmetic unit. Software loads the whole word through a single write port. From the stored word the block drives the rounding mode, as a one-hot select, and the denormal flush control. The arithmetic unit reads both.

Each time the arithmetic unit completes an operation, it presents a 5-bit raw exception vector. The block ORs any raised flags into a sticky field in the top five bits of the word. When a flag from that operation meets its matching trap-enable bit, the block raises a one-cycle assist-trap request. Only the flags of the operation just completed can cause a trap. Flags that are already sticky never do. A software write in the same cycle as an operation overrides the operation.

Top module: `fpsr_accum`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `status_word` is 0, `trap_req` is 0, `round_sel` is 4'b0001 and `flush_en` is 0.
- R2: When `wr_en` is high at a clock edge, `status_word` equals `wr_data` from the next cycle on.
- R3: `round_sel` is one-hot and decodes `status_word[10:9]`: value 0 gives bit 0 (nearest even), 1 gives bit 1 (toward zero), 2 gives bit 2 (toward plus infinity), 3 gives bit 3 (toward minus infinity).
- R4: `flush_en` equals `status_word[5]`. This one bit controls flushing of denormal operands and denormal results.
- R5: When `op_done` is high and `wr_en` is low, the next `status_word` is the old word ORed with `op_flags` shifted left by 27. Raw bit 0 (inexact) lands in word bit 27, and raw bit 4 (invalid) lands in word bit 31. All other bits keep their values.
- R6: When `op_done` is low, or `op_flags` is zero, the status word is left unchanged. The flags are sampled only when `op_done` is high, and nothing carries over between operations.
- R7: `trap_req` is high for exactly one cycle, in the cycle after an accepted operation whose `op_flags` ANDed with `status_word[4:0]` is nonzero. The enable bits used are those held before the update. In every other cycle, `trap_req` is low.
- R8: Sticky bits that are already set in `status_word[31:27]` never raise `trap_req`, even when their enables are set.
- R9: When `wr_en` and `op_done` are high in the same cycle, the written value is stored unchanged and `trap_req` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load the whole status word |
| wr_data | input | 32 | Value to load |
| op_done | input | 1 | An arithmetic operation completed this cycle |
| op_flags | input | 5 | Raw exceptions of that operation (invalid, div-zero, overflow, underflow, inexact from bit 4 down) |
| status_word | output | 32 | Current status word |
| round_sel | output | 4 | One-hot rounding mode |
| flush_en | output | 1 | Denormal flush control |
| trap_req | output | 1 | One-cycle assist-trap request |

## Verification
The bench sweeps all 1024 pairs of enable mask and raw flag vector, each starting from a preloaded sticky pattern. This sweep catches a misplaced flag bit, which would set the wrong sticky bit. It also catches a trap computed from the sticky field instead of the current flags, which would fire on old exceptions (R8). The bench checks the cycle after every operation, so a trap that stays high longer than one cycle shows up. It also applies a write and an operation together, where a design with the wrong priority would merge the flags or raise a trap. Finally, it presents flags with `op_done` low and a completion with zero flags, which would expose any accumulation outside accepted operations.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
   localparam int unsigned WORD_W     = 32;
   localparam int unsigned NFLAG      = 5;
   localparam int unsigned STICKY_LSB = 27;
   localparam int unsigned ENABLE_LSB = 0;
   localparam int unsigned RM_LSB     = 9;
   localparam int unsigned RM_W       = 2;
   localparam int unsigned FLUSH_BIT  = 5;

   typedef enum logic [1:0] {
      RM_NEAREST = 2'd0,
      RM_ZERO    = 2'd1,
      RM_PLUS    = 2'd2,
      RM_MINUS   = 2'd3
   } round_mode_e;
endpackage

// File: rtl/fpsr_round_decode.sv
module fpsr_round_decode #(
   parameter int unsigned RM_W = 2,
   localparam int unsigned NMODES = 1 << RM_W
) (
   input  logic [RM_W-1:0]   mode_field,
   output logic [NMODES-1:0] mode_onehot
);
   if (RM_W < 1) begin : g_bad_width
      $error("fpsr_round_decode: RM_W must be at least 1");
   end

   for (genvar m = 0; m < NMODES; m++) begin : g_mode
      assign mode_onehot[m] = (mode_field == RM_W'(m));
   end
endmodule

// File: rtl/fpsr_sticky_merge.sv
module fpsr_sticky_merge #(
   parameter int unsigned WORD_W     = 32,
   parameter int unsigned NFLAG      = 5,
   parameter int unsigned STICKY_LSB = 27,
   parameter int unsigned ENABLE_LSB = 0
) (
   input  logic [WORD_W-1:0] cur_word,
   input  logic [NFLAG-1:0]  raw_flags,
   input  logic              accept,
   output logic [WORD_W-1:0] next_word,
   output logic              trap_hit,
   output logic              any_flag
);
   if (STICKY_LSB + NFLAG > WORD_W) begin : g_bad_sticky
      $error("fpsr_sticky_merge: sticky field exceeds word");
   end
   if (ENABLE_LSB + NFLAG > WORD_W) begin : g_bad_enable
      $error("fpsr_sticky_merge: enable field exceeds word");
   end

   logic [NFLAG-1:0] live_flags;
   logic [NFLAG-1:0] enables;

   assign live_flags = accept ? raw_flags : '0;
   assign enables    = cur_word[ENABLE_LSB +: NFLAG];
   assign any_flag   = |live_flags;
   assign trap_hit   = |(live_flags & enables);

   for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      if (b >= STICKY_LSB && b < STICKY_LSB + NFLAG) begin : g_sticky
         assign next_word[b] = cur_word[b] | live_flags[b - STICKY_LSB];
      end else begin : g_keep
         assign next_word[b] = cur_word[b];
      end
   end
endmodule

// File: rtl/fpsr_accum.sv
module fpsr_accum
   import fpsr_pkg::*;
#(
   parameter int unsigned P_WORD_W     = WORD_W,
   parameter int unsigned P_NFLAG      = NFLAG,
   parameter int unsigned P_STICKY_LSB = STICKY_LSB,
   parameter int unsigned P_ENABLE_LSB = ENABLE_LSB,
   parameter int unsigned P_RM_LSB     = RM_LSB,
   parameter int unsigned P_RM_W       = RM_W,
   parameter int unsigned P_FLUSH_BIT  = FLUSH_BIT,
   localparam int unsigned NMODES      = 1 << P_RM_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [P_WORD_W-1:0]   wr_data,
   input  logic                  op_done,
   input  logic [P_NFLAG-1:0]    op_flags,
   output logic [P_WORD_W-1:0]   status_word,
   output logic [NMODES-1:0]     round_sel,
   output logic                  flush_en,
   output logic                  trap_req
);
   if (P_RM_LSB + P_RM_W > P_WORD_W) begin : g_bad_rm
      $error("fpsr_accum: rounding field exceeds word");
   end
   if (P_FLUSH_BIT >= P_WORD_W) begin : g_bad_flush
      $error("fpsr_accum: flush bit outside word");
   end

   logic [P_WORD_W-1:0] word_q;
   logic                trap_q;
   logic [P_WORD_W-1:0] merged;
   logic                trap_hit;
   logic                any_flag;

   fpsr_sticky_merge #(
      .WORD_W     (P_WORD_W),
      .NFLAG      (P_NFLAG),
      .STICKY_LSB (P_STICKY_LSB),
      .ENABLE_LSB (P_ENABLE_LSB)
   ) u_merge (
      .cur_word  (word_q),
      .raw_flags (op_flags),
      .accept    (op_done),
      .next_word (merged),
      .trap_hit  (trap_hit),
      .any_flag  (any_flag)
   );

   fpsr_round_decode #(
      .RM_W (P_RM_W)
   ) u_round (
      .mode_field  (word_q[P_RM_LSB +: P_RM_W]),
      .mode_onehot (round_sel)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
         trap_q <= 1'b0;
      end else if (wr_en) begin
         word_q <= wr_data;
         trap_q <= 1'b0;
      end else if (any_flag) begin
         word_q <= merged;
         trap_q <= trap_hit;
      end else begin
         trap_q <= 1'b0;
      end
   end

   assign status_word = word_q;
   assign flush_en    = word_q[P_FLUSH_BIT];
   assign trap_req    = trap_q;

   // R2 / R9: a write is stored verbatim and suppresses any trap
   a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (status_word == $past(wr_data)) && !trap_req);

   // R5: accepted flags are ORed into the sticky field
   a_r5_sticky_or: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && op_done) |=>
         status_word == ($past(status_word) |
                         (P_WORD_W'($past(op_flags)) << P_STICKY_LSB)));

   // R6: nothing accepted means no change and no trap
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && (!op_done || op_flags == '0)) |=>
         $stable(status_word) && !trap_req);

   // R7 / R8: a trap needs a current flag meeting its enable
   a_r7_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> $past(!wr_en && op_done &&
         ((op_flags & status_word[P_ENABLE_LSB +: P_NFLAG]) != '0)));

   // R3: rounding select is always one-hot
   a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(round_sel) == 1);
endmodule

// File: tb/fpsr_accum_test.sv
module fpsr_accum_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        op_done = 1'b0;
   logic [4:0]  op_flags = '0;
   logic [31:0] status_word;
   logic [3:0]  round_sel;
   logic        flush_en;
   logic        trap_req;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpsr_accum uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .op_done(op_done), .op_flags(op_flags), .status_word(status_word),
      .round_sel(round_sel), .flush_en(flush_en), .trap_req(trap_req)
   );

   task automatic chk(input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [31:0] w);
      @(negedge clk);
      wr_en = 1'b1; wr_data = w;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_op(input logic done, input logic [4:0] f);
      @(negedge clk);
      op_done = done; op_flags = f;
      @(negedge clk);
      op_done = 1'b0; op_flags = '0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (2000 * 4 + 20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: values held in reset
      chk("R1 status", status_word, 32'h0);
      chk("R1 trap", {31'b0, trap_req}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 status after", status_word, 32'h0);
      chk("R1 round", {28'b0, round_sel}, 32'h1);
      chk("R1 flush", {31'b0, flush_en}, 32'h0);

      // R3 / R4: rounding decode and flush for every mode
      for (int m = 0; m < 4; m++) begin
         for (int fl = 0; fl < 2; fl++) begin
            logic [31:0] w;
            w = (32'(m) << 9) | (32'(fl) << 5) | 32'h0000_1000;
            do_write(w);
            chk("R2 load", status_word, w);
            chk("R3 round", {28'b0, round_sel}, 32'h1 << m);
            chk("R4 flush", {31'b0, flush_en}, 32'(fl));
         end
      end

      // R5 / R7 / R8: full sweep of enables against raw flags
      for (int e = 0; e < 32; e++) begin
         for (int f = 0; f < 32; f++) begin
            logic [31:0] base, exp;
            base = 32'(e) | (32'((e * 7) & 31) << 27) | (32'(e) << 11);
            exp  = base | (32'(f) << 27);
            do_write(base);
            do_op(1'b1, 5'(f));
            chk("R5 merge", status_word, exp);
            chk("R7 trap", {31'b0, trap_req}, {31'b0, ((e & f) != 0)});
            @(negedge clk);
            chk("R7 pulse width", {31'b0, trap_req}, 32'h0);
         end
      end

      // R8: sticky bits already set with enables set do not trap
      do_write(32'hF800_001F);
      do_op(1'b1, 5'h00);
      chk("R8 no trap", {31'b0, trap_req}, 32'h0);
      chk("R6 zero flags", status_word, 32'hF800_001F);

      // R6: flags without op_done are ignored
      do_write(32'h0000_001F);
      do_op(1'b0, 5'h1F);
      chk("R6 ignored status", status_word, 32'h0000_001F);
      chk("R6 ignored trap", {31'b0, trap_req}, 32'h0);
      do_op(1'b1, 5'h00);
      chk("R6 no carryover", status_word, 32'h0000_001F);

      // R9: write wins over a simultaneous operation
      @(negedge clk);
      wr_en = 1'b1; wr_data = 32'h0000_021F;
      op_done = 1'b1; op_flags = 5'h1F;
      @(negedge clk);
      wr_en = 1'b0; op_done = 1'b0; op_flags = '0;
      chk("R9 status", status_word, 32'h0000_021F);
      chk("R9 trap", {31'b0, trap_req}, 32'h0);

      finish_run();
   end
endmodule